// File: doc/BRIEF.md
# Locality Register Decoder

This block sits between a host byte bus and the register file of a trusted platform module. It takes one byte access per request and works out which register, which FIFO byte lane or which hash control the access is meant for. The register file and the FIFO storage live outside the block. The decoder hands them select lines, read and write strobes and the write byte. It returns the read byte, registered, one cycle after the request.

Two addressing schemes are offered, picked by an input pin.

- **Memory mode.** The decoder claims a 20 KB window made of five 4 KB pages. The page number is the requesting locality. The common registers appear in every page and all point at one shared copy. The byte lanes at offsets 0x024 to 0x027 are the data FIFO in localities 0 to 3. In locality 4 those same lanes become the hash data input, and only there do the hash start and hash end controls exist.
- **Port mode.** Two I/O ports work as a pointer and a window. The port at the programmable base holds an index. The port at base plus one reaches the register that the index names.

The block reports the locality of the last access it claimed. It answers 0xFF for any location it does not define, and it drops writes to such locations.

Top module: `loc_reg_decode`

## Requirements
- R1: With legacyMode low, an access is claimed only when busAddr[31:16] is 0xFED4 and busAddr[15:12] is 0 to 4; that nibble is the locality. Any other address gets no busAck and raises no strobe.
- R2: In memory mode, offset 0x000 and offsets 0x008–0x00C and 0x010–0x01A (busAddr[11:0]) raise regRd or regWr for the request cycle, in any locality. regSel is 0x00 for offset 0x000 and busAddr[5:0] otherwise, so every page reaches the same register.
- R3: Offsets 0xF00–0xF03 read as the bytes 0x4A, 0x10, 0x00, 0x00 (least significant byte first), and offset 0xF04 reads as 0x4E. Writes to these offsets raise no strobe and do not change what is read back.
- R4: A read of any memory-mode offset not defined by R2, R3, R5, R6 or R7 returns 0xFF. A write to such an offset raises no strobe.
- R5: In locality 4, a write to offset 0x028 pulses hashStart and a write to offset 0x020 pulses hashEnd, each for one cycle. In other localities these offsets are undefined. A read of either offset returns 0xFF.
- R6: In locality 4, a write to offsets 0x024–0x027 pulses hashData with strbLoc = 4 and wrByte = busWdata, and raises no FIFO strobe. A read of those offsets returns 0xFF with no pop.
- R7: In localities 0–3, a write to offsets 0x024–0x027 pulses fifoPush and a read pulses fifoPop, with strbLoc equal to the locality. A write passes busWdata on wrByte. A read returns fifoRdata.
- R8: With legacyMode high, the port at ioBase is a read/write index register. It resets to 0x00 and keeps its value across accesses to the data port.
- R9: With legacyMode high, the port at ioBase+1 is the data port and is routed by the index. Index 0x00–0x04, 0x08–0x0C and 0x10–0x1A give a register access with regSel equal to the index. Index 0x24–0x27 gives a FIFO access with strbLoc = 0. Index 0x29–0x2C reads the ID bytes 0x4A, 0x10, 0x00, 0x00.
- R10: A data-port access with any other index reads 0xFF and raises no strobe on a write. Port mode ignores the memory window, and memory mode ignores the I/O ports.
- R11: busAck rises in the cycle after each claimed request. In that same cycle busRdata holds the read byte, or 0x00 for a write.
- R12: activeLoc resets to 0. It takes the locality of each claimed memory-mode access, and it takes 0 on each claimed port-mode access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| legacyMode | input | 1 | 1 selects index/data port mode, 0 selects the memory window |
| ioBase | input | 16 | I/O address of the index port |
| busValid | input | 1 | Byte access request, one cycle per access |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 8 | Write byte |
| busAck | output | 1 | Claimed-access response, one cycle after the request |
| busRdata | output | 8 | Read byte returned with busAck |
| regSel | output | 6 | Register byte select toward the register file |
| regRd | output | 1 | Register read strobe |
| regWr | output | 1 | Register write strobe |
| regRdata | input | 8 | Byte returned by the register file for regSel |
| fifoPush | output | 1 | FIFO write strobe |
| fifoPop | output | 1 | FIFO read strobe |
| fifoRdata | input | 8 | FIFO head byte |
| hashStart | output | 1 | Hash start write strobe |
| hashEnd | output | 1 | Hash end write strobe |
| hashData | output | 1 | Hash data byte strobe |
| strbLoc | output | 3 | Locality travelling with the FIFO and hash strobes |
| wrByte | output | 8 | Write byte toward the register file, FIFO and hash unit |
| activeLoc | output | 3 | Locality of the last claimed access |

## Verification
The sharpest corner is the shared lane range 0x024–0x027. A decoder that ignores the locality would push hash bytes into the FIFO, or pop the FIFO on a locality-4 read. The bench also writes the hash start offset from locality 1 and reads it from locality 4; a decoder that gated on the offset alone would fire a spurious strobe there. Further tests probe the window edges (page 5, a wrong upper half), read-only ID bytes after a write, an index that must survive data-port traffic, and a port-mode fall-through index. Each of these exposes a decoder that claims too much or lets a discarded write leak through.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int LOC_W = 3;
  localparam int SEL_W = 6;
  localparam int OFF_W = 12;

  typedef struct packed {
    logic             hit;
    logic             isWrite;
    logic             regAcc;
    logic             fifoAcc;
    logic             hashDat;
    logic             hashBeg;
    logic             hashFin;
    logic             idAcc;
    logic             idxAcc;
    logic [2:0]       idByte;
    logic [SEL_W-1:0] sel;
    logic [LOC_W-1:0] loc;
  } decStrb_t;
endpackage

// File: rtl/lrd_ctrl.sv
module lrd_ctrl
  import lrd_pkg::*;
#(
  parameter logic [15:0] WIN_HI    = 16'hFED4,
  parameter int          LOC_COUNT = 5,
  parameter int          HASH_LOC  = 4
) (
  input  logic        legacyMode,
  input  logic [15:0] ioBase,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [31:0] busAddr,
  input  logic [7:0]  idxVal,
  output decStrb_t    strb
);
  localparam logic [LOC_W-1:0] HASH_L = LOC_W'(HASH_LOC);

  logic [OFF_W-1:0] off;
  logic [LOC_W-1:0] pageLoc;
  logic             inWin;
  logic             idxPort;
  logic             datPort;
  logic [7:0]       idOff;

  assign off     = busAddr[OFF_W-1:0];
  assign pageLoc = busAddr[OFF_W +: LOC_W];
  assign inWin   = (busAddr[31:16] == WIN_HI) && (busAddr[15:12] < 4'(LOC_COUNT));
  assign idxPort = busAddr[15:0] == ioBase;
  assign datPort = busAddr[15:0] == (ioBase + 16'd1);
  assign idOff   = idxVal - 8'h29;

  always_comb begin
    strb         = '0;
    strb.isWrite = busWrite;
    if (!legacyMode) begin
      if (busValid && inWin) begin
        strb.hit = 1'b1;
        strb.loc = pageLoc;
        if (off == 12'h000) begin
          strb.regAcc = 1'b1;
          strb.sel    = '0;
        end else if ((off >= 12'h008 && off <= 12'h00C) ||
                     (off >= 12'h010 && off <= 12'h01A)) begin
          strb.regAcc = 1'b1;
          strb.sel    = off[SEL_W-1:0];
        end else if (off >= 12'h024 && off <= 12'h027) begin
          if (pageLoc == HASH_L) strb.hashDat = 1'b1;
          else                   strb.fifoAcc = 1'b1;
        end else if (off == 12'h020 && pageLoc == HASH_L) begin
          strb.hashFin = 1'b1;
        end else if (off == 12'h028 && pageLoc == HASH_L) begin
          strb.hashBeg = 1'b1;
        end else if (off >= 12'hF00 && off <= 12'hF04) begin
          strb.idAcc  = 1'b1;
          strb.idByte = off[2:0];
        end
      end
    end else begin
      if (busValid && idxPort) begin
        strb.hit    = 1'b1;
        strb.idxAcc = 1'b1;
      end else if (busValid && datPort) begin
        strb.hit = 1'b1;
        if (idxVal <= 8'h04 ||
            (idxVal >= 8'h08 && idxVal <= 8'h0C) ||
            (idxVal >= 8'h10 && idxVal <= 8'h1A)) begin
          strb.regAcc = 1'b1;
          strb.sel    = idxVal[SEL_W-1:0];
        end else if (idxVal >= 8'h24 && idxVal <= 8'h27) begin
          strb.fifoAcc = 1'b1;
        end else if (idxVal >= 8'h29 && idxVal <= 8'h2C) begin
          strb.idAcc  = 1'b1;
          strb.idByte = idOff[2:0];
        end
      end
    end
  end
endmodule

// File: rtl/lrd_dpath.sv
module lrd_dpath
  import lrd_pkg::*;
#(
  parameter logic [31:0] DEVVEN_ID = 32'h0000_104A,
  parameter logic [7:0]  REV_ID    = 8'h4E
) (
  input  logic             clk,
  input  logic             rstN,
  input  decStrb_t         strb,
  input  logic [7:0]       busWdata,
  input  logic [7:0]       regRdata,
  input  logic [7:0]       fifoRdata,
  output logic [7:0]       idxVal,
  output logic [SEL_W-1:0] regSel,
  output logic             regRd,
  output logic             regWr,
  output logic             fifoPush,
  output logic             fifoPop,
  output logic             hashStart,
  output logic             hashEnd,
  output logic             hashData,
  output logic [LOC_W-1:0] strbLoc,
  output logic [7:0]       wrByte,
  output logic             busAck,
  output logic [7:0]       busRdata,
  output logic [LOC_W-1:0] activeLoc
);
  logic       wr;
  logic       rd;
  logic [7:0] idData;
  logic [7:0] rdMux;

  assign wr = strb.hit && strb.isWrite;
  assign rd = strb.hit && !strb.isWrite;

  assign regSel    = strb.sel;
  assign regWr     = wr && strb.regAcc;
  assign regRd     = rd && strb.regAcc;
  assign fifoPush  = wr && strb.fifoAcc;
  assign fifoPop   = rd && strb.fifoAcc;
  assign hashStart = wr && strb.hashBeg;
  assign hashEnd   = wr && strb.hashFin;
  assign hashData  = wr && strb.hashDat;
  assign strbLoc   = strb.loc;
  assign wrByte    = busWdata;

  always_comb begin
    case (strb.idByte)
      3'd0:    idData = DEVVEN_ID[7:0];
      3'd1:    idData = DEVVEN_ID[15:8];
      3'd2:    idData = DEVVEN_ID[23:16];
      3'd3:    idData = DEVVEN_ID[31:24];
      default: idData = REV_ID;
    endcase
  end

  always_comb begin
    if (strb.regAcc)       rdMux = regRdata;
    else if (strb.fifoAcc) rdMux = fifoRdata;
    else if (strb.idAcc)   rdMux = idData;
    else if (strb.idxAcc)  rdMux = idxVal;
    else                   rdMux = 8'hFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxVal    <= 8'h00;
      busAck    <= 1'b0;
      busRdata  <= 8'h00;
      activeLoc <= '0;
    end else begin
      busAck <= strb.hit;
      if (rd)       busRdata <= rdMux;
      else          busRdata <= 8'h00;
      if (strb.hit) activeLoc <= strb.loc;
      if (wr && strb.idxAcc) idxVal <= busWdata;
    end
  end
endmodule

// File: rtl/loc_reg_decode.sv
module loc_reg_decode
  import lrd_pkg::*;
#(
  parameter logic [15:0] WIN_HI    = 16'hFED4,
  parameter int          LOC_COUNT = 5,
  parameter int          HASH_LOC  = 4,
  parameter logic [31:0] DEVVEN_ID = 32'h0000_104A,
  parameter logic [7:0]  REV_ID    = 8'h4E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        legacyMode,
  input  logic [15:0] ioBase,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [31:0] busAddr,
  input  logic [7:0]  busWdata,
  output logic        busAck,
  output logic [7:0]  busRdata,
  output logic [5:0]  regSel,
  output logic        regRd,
  output logic        regWr,
  input  logic [7:0]  regRdata,
  output logic        fifoPush,
  output logic        fifoPop,
  input  logic [7:0]  fifoRdata,
  output logic        hashStart,
  output logic        hashEnd,
  output logic        hashData,
  output logic [2:0]  strbLoc,
  output logic [7:0]  wrByte,
  output logic [2:0]  activeLoc
);
  decStrb_t   strb;
  logic [7:0] idxVal;

  lrd_ctrl #(
    .WIN_HI(WIN_HI), .LOC_COUNT(LOC_COUNT), .HASH_LOC(HASH_LOC)
  ) u_ctrl (
    .legacyMode(legacyMode), .ioBase(ioBase), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .idxVal(idxVal), .strb(strb)
  );

  lrd_dpath #(
    .DEVVEN_ID(DEVVEN_ID), .REV_ID(REV_ID)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .regRdata(regRdata), .fifoRdata(fifoRdata), .idxVal(idxVal),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .fifoPush(fifoPush),
    .fifoPop(fifoPop), .hashStart(hashStart), .hashEnd(hashEnd),
    .hashData(hashData), .strbLoc(strbLoc), .wrByte(wrByte),
    .busAck(busAck), .busRdata(busRdata), .activeLoc(activeLoc)
  );
endmodule

// File: rtl/lrd_check.sv
module lrd_check (
  input logic        clk,
  input logic        rstN,
  input logic        legacyMode,
  input logic        busValid,
  input logic        busWrite,
  input logic        busAck,
  input logic        regRd,
  input logic        regWr,
  input logic        fifoPush,
  input logic        fifoPop,
  input logic        hashStart,
  input logic        hashEnd,
  input logic        hashData,
  input logic [2:0]  strbLoc,
  input logic [2:0]  activeLoc
);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regRd, regWr, fifoPush, fifoPop, hashStart, hashEnd, hashData}));

  p_strobe_needs_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr || fifoPush || fifoPop || hashStart || hashEnd || hashData) |-> busValid);

  p_ack_after_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busValid));

  p_hash_loc4_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hashStart || hashEnd || hashData) |-> (strbLoc == 3'd4 && busWrite && !legacyMode));

  p_fifo_not_loc4_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPush || fifoPop) |-> strbLoc != 3'd4);

  p_legacy_loc0_r9: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && (fifoPush || fifoPop)) |-> strbLoc == 3'd0);

  p_loc_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    activeLoc <= 3'd4);
endmodule

bind loc_reg_decode lrd_check u_chk (.*);

// File: tb/sim_loc_reg_decode.sv
module sim_loc_reg_decode;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        legacyMode = 1'b0;
  logic [15:0] ioBase = 16'h0300;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        busAck;
  logic [7:0]  busRdata;
  logic [5:0]  regSel;
  logic        regRd, regWr, fifoPush, fifoPop, hashStart, hashEnd, hashData;
  logic [7:0]  regRdata;
  logic [7:0]  fifoRdata;
  logic [2:0]  strbLoc;
  logic [7:0]  wrByte;
  logic [2:0]  activeLoc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // strobe code bits: 6 regWr, 5 regRd, 4 push, 3 pop, 2 hashStart, 1 hashEnd, 0 hashData
  logic [6:0] sStrb;
  logic [5:0] sSel;
  logic [2:0] sLoc;
  logic [7:0] sByte;
  logic       sAck;
  logic [7:0] sRd;

  localparam logic [6:0] S_NONE = 7'h00, S_WR = 7'h40, S_RD = 7'h20, S_PUSH = 7'h10,
                         S_POP = 7'h08, S_HS = 7'h04, S_HE = 7'h02, S_HD = 7'h01;

  always #2 clk = ~clk;

  assign regRdata  = {2'b10, regSel};
  assign fifoRdata = 8'h5A;

  loc_reg_decode u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    #1;
    sStrb = {regWr, regRd, fifoPush, fifoPop, hashStart, hashEnd, hashData};
    sSel = regSel; sLoc = strbLoc; sByte = wrByte;
    @(negedge clk);
    sAck = busAck; sRd = busRdata;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset ack", busAck, 0);
    chk("R12 reset loc", activeLoc, 0);
  endtask

  task automatic t_regs;
    acc(0, 32'hFED4_2018, 0);
    chk("R2 status rd strobe", sStrb, S_RD);
    chk("R2 status sel", sSel, 6'h18);
    chk("R11 ack", sAck, 1);
    chk("R11 rdata", sRd, 8'h98);
    chk("R12 loc2", activeLoc, 2);
    acc(1, 32'hFED4_3000, 8'h11);
    chk("R2 access alias wr", sStrb, S_WR);
    chk("R2 access alias sel", sSel, 0);
    chk("R11 write rdata", sRd, 0);
    chk("R12 loc3", activeLoc, 3);
  endtask

  task automatic t_id;
    logic [7:0] exp [5] = '{8'h4A, 8'h10, 8'h00, 8'h00, 8'h4E};
    for (int i = 0; i < 5; i++) begin
      acc(0, 32'hFED4_1F00 + i, 0);
      chk("R3 id byte", sRd, exp[i]);
    end
    acc(1, 32'hFED4_0F00, 8'h77);
    chk("R3 id write no strobe", sStrb, S_NONE);
    acc(0, 32'hFED4_0F00, 0);
    chk("R3 id unchanged", sRd, 8'h4A);
  endtask

  task automatic t_undef;
    acc(0, 32'hFED4_0030, 0);
    chk("R4 undef rd", sRd, 8'hFF);
    chk("R4 undef rd ack", sAck, 1);
    acc(1, 32'hFED4_0030, 8'h33);
    chk("R4 undef wr strobe", sStrb, S_NONE);
    acc(0, 32'hFED4_5000, 0);
    chk("R1 page5 no ack", sAck, 0);
    acc(1, 32'hFED5_0000, 8'h1);
    chk("R1 outside no strobe", sStrb, S_NONE);
    chk("R1 outside no ack", sAck, 0);
  endtask

  task automatic t_hash;
    acc(1, 32'hFED4_4028, 0);
    chk("R5 hash start", sStrb, S_HS);
    chk("R5 hash start loc", sLoc, 4);
    acc(1, 32'hFED4_4020, 0);
    chk("R5 hash end", sStrb, S_HE);
    acc(1, 32'hFED4_1028, 0);
    chk("R5 start loc1 none", sStrb, S_NONE);
    acc(0, 32'hFED4_4028, 0);
    chk("R5 start read ff", sRd, 8'hFF);
    chk("R5 start read no strobe", sStrb, S_NONE);
    acc(1, 32'hFED4_4025, 8'hAB);
    chk("R6 hash data", sStrb, S_HD);
    chk("R6 hash byte", sByte, 8'hAB);
    acc(0, 32'hFED4_4026, 0);
    chk("R6 hash data read no pop", sStrb, S_NONE);
    chk("R6 hash data read ff", sRd, 8'hFF);
  endtask

  task automatic t_fifo;
    acc(1, 32'hFED4_1026, 8'hCD);
    chk("R7 push", sStrb, S_PUSH);
    chk("R7 push loc", sLoc, 1);
    chk("R7 push byte", sByte, 8'hCD);
    acc(0, 32'hFED4_3024, 0);
    chk("R7 pop", sStrb, S_POP);
    chk("R7 pop loc", sLoc, 3);
    chk("R7 pop data", sRd, 8'h5A);
  endtask

  task automatic t_legacy;
    legacyMode = 1'b1;
    acc(0, 32'h0000_0300, 0);
    chk("R8 index reset", sRd, 0);
    chk("R12 legacy loc0", activeLoc, 0);
    acc(1, 32'h0000_0300, 8'h09);
    acc(0, 32'h0000_0301, 0);
    chk("R9 data reg rd", sStrb, S_RD);
    chk("R9 data reg sel", sSel, 6'h09);
    chk("R9 data rdata", sRd, 8'h89);
    acc(0, 32'h0000_0300, 0);
    chk("R8 index held", sRd, 8'h09);
    acc(1, 32'h0000_0300, 8'h03);
    acc(1, 32'h0000_0301, 8'h44);
    chk("R9 access3 wr", sStrb, S_WR);
    chk("R9 access3 sel", sSel, 3);
    acc(1, 32'h0000_0300, 8'h2A);
    acc(0, 32'h0000_0301, 0);
    chk("R9 id byte", sRd, 8'h10);
    acc(1, 32'h0000_0300, 8'h25);
    acc(1, 32'h0000_0301, 8'h66);
    chk("R9 fifo push", sStrb, S_PUSH);
    chk("R9 fifo loc0", sLoc, 0);
    acc(1, 32'h0000_0300, 8'h40);
    acc(0, 32'h0000_0301, 0);
    chk("R10 undef idx ff", sRd, 8'hFF);
    acc(1, 32'h0000_0301, 8'h1);
    chk("R10 undef idx no strobe", sStrb, S_NONE);
    acc(0, 32'hFED4_0000, 0);
    chk("R10 legacy ignores window", sAck, 0);
    ioBase = 16'h002E;
    acc(0, 32'h0000_002E, 0);
    chk("R8 moved base index", sRd, 8'h40);
    legacyMode = 1'b0;
    acc(0, 32'h0000_002E, 0);
    chk("R10 memory ignores port", sAck, 0);
  endtask

  initial begin
    #4 t_reset();
    #6 rstN = 1'b1;
    t_regs();
    t_id();
    t_undef();
    t_hash();
    t_fifo();
    t_legacy();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule